// File: doc/BRIEF.md
# Five-Port Wormhole Mesh Router

This block is one switching node of a two-dimensional mesh. It has five ports: a local port to the attached node, plus one port for each compass neighbour. Every port has an input side and an output side, and each side uses a valid/ready handshake. A packet is a worm of flits. It starts with a head flit that holds the destination as absolute mesh coordinates. Zero or more body flits follow, and a tail flit closes the packet. A packet that is a single flit marks that flit as both head and tail.

Each input queues arriving flits in a shallow FIFO. A worm can be longer than this FIFO. When a head flit reaches the front of its FIFO, the router computes its output by dimension order. It first moves the flit along X until the column matches, then along Y, and ejects it locally when both coordinates match. Every output has a round-robin arbiter that picks one head among all inputs asking for that output while it is free. The winner owns the output until its tail flit has left. A crossbar then forwards the owner's flits one per cycle, whenever the neighbour downstream is ready. Body and tail flits are never routed: they follow the path their head reserved.

The router's own coordinates arrive on input pins. This lets one design serve every node of the mesh.

Top module: `mesh_router`

## Requirements
- R1: After a synchronous active-low reset, no output presents a valid flit and every input reports ready.
- R2: Port indices are local=0, north=1, south=2, east=3, west=4. A head flit goes east if its destination X (payload bits [1:0]) is greater than the router X, and west if it is less. Otherwise it goes north if its destination Y (payload bits [3:2]) is greater than the router Y, and south if it is less. If both coordinates match, it goes to local.
- R3: A flit leaves the router with exactly the bits it arrived with. Body and tail flits take the output their head took, in arrival order. Flit bit 9 marks a head and bit 8 marks a tail.
- R4: Once an output carries a head flit, it carries no flit from any other input until that worm's tail flit has left.
- R5: When several inputs hold head flits for the same free output, they are granted in rotating order. Two inputs that contend for the same output continuously alternate packet by packet.
- R6: A flit leaves an output only in a cycle where that output's ready is high. While it is held back, the flit stays presented and unchanged. When an input FIFO is full, that input's ready falls, and no flit is dropped.
- R7: A packet that is a single flit both takes and releases its output, so a later packet can use the same output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cur_x | input | COORD_W | X coordinate of this router |
| cur_y | input | COORD_W | Y coordinate of this router |
| in_valid | input | 5 | Per input port: a flit is offered |
| in_flit | input | 5 x (DATA_W+2) | Per input port: the offered flit, as {head, tail, payload} |
| in_ready | output | 5 | Per input port: the FIFO can accept a flit |
| out_valid | output | 5 | Per output port: a flit is presented |
| out_flit | output | 5 x (DATA_W+2) | Per output port: the presented flit |
| out_ready | input | 5 | Per output port: the downstream neighbour accepts the flit |

## Verification
Suppose the ownership record of an output is wrong, for example an owner changes mid-worm or a release is missed. Then, within a few cycles of the next head arriving, one of two things shows at that output: flits from two sources interleave, or later packets never appear. A wrong route decision shows on the very first flit as the wrong output port, two clock edges after the flit is accepted. A broken stall path shows as a lost or duplicated flit, or as a flit that changes while ready is low. The bench sweeps every destination from every input at two router positions. It also runs contention, long-worm and backpressure scenarios, and it compares every flit observed at the outputs against sequences it computes from the requirements.

// File: rtl/mesh_router_pkg.sv
// Shared constants and types for the mesh router.
// Port numbering is fixed because neighbours and the route unit agree on it.
package mesh_router_pkg;
    localparam int NUM_PORTS = 5;
    localparam int PORT_W    = 3;
    typedef logic [PORT_W-1:0] port_t;
    localparam port_t P_LOCAL = 3'd0;
    localparam port_t P_NORTH = 3'd1;
    localparam port_t P_SOUTH = 3'd2;
    localparam port_t P_EAST  = 3'd3;
    localparam port_t P_WEST  = 3'd4;
endpackage

// File: rtl/flit_fifo.sv
// Small synchronous FIFO holding flits for one input port.
// Assumes the caller never pushes when full nor pops when empty.
// The front entry is visible combinationally on dout.
module flit_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         not_empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    // Storage write, no reset needed on data.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // Front entry and flags.
    assign dout      = mem[rd_ptr];
    assign not_empty = (count != '0);
    assign full      = (count == CW'(DEPTH));
endmodule

// File: rtl/xy_route.sv
// Dimension-order route computation: X is resolved fully before Y.
// Assumes absolute coordinates and a mesh (no wrap links).
module xy_route
    import mesh_router_pkg::*;
#(
    parameter int COORD_W = 2
) (
    input  logic [COORD_W-1:0] dest_x,
    input  logic [COORD_W-1:0] dest_y,
    input  logic [COORD_W-1:0] cur_x,
    input  logic [COORD_W-1:0] cur_y,
    output port_t              port
);
    // Pick the single productive direction, X first.
    always_comb begin
        if (dest_x > cur_x)      port = P_EAST;
        else if (dest_x < cur_x) port = P_WEST;
        else if (dest_y > cur_y) port = P_NORTH;
        else if (dest_y < cur_y) port = P_SOUTH;
        else                     port = P_LOCAL;
    end
endmodule

// File: rtl/rr_arbiter.sv
// Round-robin arbiter: one-hot grant to the first requester at or after
// the pointer; the pointer moves to just past the winner on any grant.
module rr_arbiter #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr;
    logic [IW-1:0] win;

    // Search requesters in rotating order starting at the pointer.
    always_comb begin
        gnt = '0;
        win = ptr;
        for (int off = 0; off < N; off++) begin
            int idx;
            idx = int'(ptr) + off;
            if (idx >= N) idx = idx - N;
            if (gnt == '0 && req[idx]) begin
                gnt[idx] = 1'b1;
                win      = IW'(idx);
            end
        end
    end

    // Advance the pointer past the winner.
    always_ff @(posedge clk) begin
        if (!rst_n)     ptr <= '0;
        else if (|req)  ptr <= (win == IW'(N - 1)) ? '0 : win + 1'b1;
    end
endmodule

// File: rtl/mesh_router.sv
// Five-port wormhole router with XY routing.
// Flit = {head, tail, payload}; head payload [COORD_W-1:0] is dest X and
// [2*COORD_W-1:COORD_W] is dest Y. Assumes well-formed worms (head first,
// tail last) and DATA_W >= 2*COORD_W. Stages: input FIFO + route compute,
// switch allocation (registered ownership), switch traversal to the output.
module mesh_router
    import mesh_router_pkg::*;
#(
    parameter int COORD_W    = 2,
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [COORD_W-1:0]                  cur_x,
    input  logic [COORD_W-1:0]                  cur_y,
    input  logic [NUM_PORTS-1:0]                in_valid,
    input  logic [NUM_PORTS-1:0][DATA_W+1:0]    in_flit,
    output logic [NUM_PORTS-1:0]                in_ready,
    output logic [NUM_PORTS-1:0]                out_valid,
    output logic [NUM_PORTS-1:0][DATA_W+1:0]    out_flit,
    input  logic [NUM_PORTS-1:0]                out_ready
);
    localparam int NP       = NUM_PORTS;
    localparam int FLIT_W   = DATA_W + 2;
    localparam int HEAD_BIT = FLIT_W - 1;
    localparam int TAIL_BIT = FLIT_W - 2;

    logic [FLIT_W-1:0] f_data [NP];
    logic [NP-1:0]     f_valid, f_full, f_pop;
    port_t             rport [NP];

    logic [NP-1:0]     req [NP];
    logic [NP-1:0]     gnt [NP];
    logic [NP-1:0]     gnt_any;
    port_t             gnt_idx [NP];
    logic [NP-1:0]     in_gnt_any;
    port_t             in_gnt_out [NP];

    logic [NP-1:0]     out_busy;
    port_t             out_owner [NP];
    logic [NP-1:0]     in_locked;
    port_t             in_out [NP];

    // Per-input FIFO and route unit.
    for (genvar i = 0; i < NP; i++) begin : g_in
        flit_fifo #(.W(FLIT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk(clk), .rst_n(rst_n),
            .push(in_valid[i] && !f_full[i]), .din(in_flit[i]),
            .pop(f_pop[i]), .dout(f_data[i]),
            .not_empty(f_valid[i]), .full(f_full[i])
        );
        xy_route #(.COORD_W(COORD_W)) u_route (
            .dest_x(f_data[i][COORD_W-1:0]),
            .dest_y(f_data[i][2*COORD_W-1:COORD_W]),
            .cur_x(cur_x), .cur_y(cur_y),
            .port(rport[i])
        );
        assign in_ready[i] = !f_full[i];
    end

    // Per-output arbiter.
    for (genvar o = 0; o < NP; o++) begin : g_out
        rr_arbiter #(.N(NP)) u_arb (
            .clk(clk), .rst_n(rst_n), .req(req[o]), .gnt(gnt[o])
        );
    end

    // Head flits of unlocked inputs request their free routed output.
    always_comb begin
        for (int o = 0; o < NP; o++)
            for (int i = 0; i < NP; i++)
                req[o][i] = f_valid[i] && f_data[i][HEAD_BIT] && !in_locked[i]
                            && (rport[i] == PORT_W'(o)) && !out_busy[o];
    end

    // Encode grants per output and per input.
    always_comb begin
        for (int i = 0; i < NP; i++) begin
            in_gnt_any[i] = 1'b0;
            in_gnt_out[i] = '0;
        end
        for (int o = 0; o < NP; o++) begin
            gnt_any[o] = |gnt[o];
            gnt_idx[o] = '0;
            for (int i = 0; i < NP; i++) begin
                if (gnt[o][i]) begin
                    gnt_idx[o]    = PORT_W'(i);
                    in_gnt_any[i] = 1'b1;
                    in_gnt_out[i] = PORT_W'(o);
                end
            end
        end
    end

    // Crossbar: each owned output shows its owner's front flit.
    always_comb begin
        for (int o = 0; o < NP; o++) begin
            out_flit[o]  = '0;
            out_valid[o] = 1'b0;
            for (int i = 0; i < NP; i++) begin
                if (out_owner[o] == PORT_W'(i)) begin
                    out_flit[o]  = f_data[i];
                    out_valid[o] = out_busy[o] && f_valid[i];
                end
            end
        end
    end

    // An input pops when its locked output is accepted downstream.
    always_comb begin
        for (int i = 0; i < NP; i++) begin
            f_pop[i] = 1'b0;
            for (int o = 0; o < NP; o++)
                if (in_out[i] == PORT_W'(o))
                    f_pop[i] = in_locked[i] && f_valid[i] && out_ready[o];
        end
    end

    // Output ownership: take on grant, release when the tail leaves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_busy <= '0;
            for (int o = 0; o < NP; o++) out_owner[o] <= '0;
        end else begin
            for (int o = 0; o < NP; o++) begin
                if (gnt_any[o]) begin
                    out_busy[o]  <= 1'b1;
                    out_owner[o] <= gnt_idx[o];
                end else if (out_valid[o] && out_ready[o] && out_flit[o][TAIL_BIT]) begin
                    out_busy[o]  <= 1'b0;
                end
            end
        end
    end

    // Input lock: remembers the output reserved by its worm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_locked <= '0;
            for (int i = 0; i < NP; i++) in_out[i] <= '0;
        end else begin
            for (int i = 0; i < NP; i++) begin
                if (in_gnt_any[i]) begin
                    in_locked[i] <= 1'b1;
                    in_out[i]    <= in_gnt_out[i];
                end else if (f_pop[i] && f_data[i][TAIL_BIT]) begin
                    in_locked[i] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/mesh_router_chk.sv
// Assertion checker bound to mesh_router; observes ports and ownership state.
module mesh_router_chk
    import mesh_router_pkg::*;
#(
    parameter int FLIT_W = 10
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_PORTS-1:0]          out_valid,
    input logic [NUM_PORTS-1:0]          out_ready,
    input logic [NUM_PORTS-1:0][FLIT_W-1:0] out_flit,
    input logic [NUM_PORTS-1:0]          out_busy,
    input port_t                         out_owner [NUM_PORTS]
);
    localparam int NP = NUM_PORTS;
    localparam int TAIL_BIT = FLIT_W - 2;

    logic [NP-1:0] owned_by [NP];

    // Which outputs each input currently owns.
    always_comb begin
        for (int i = 0; i < NP; i++)
            for (int o = 0; o < NP; o++)
                owned_by[i][o] = out_busy[o] && (out_owner[o] == PORT_W'(i));
    end

    for (genvar o = 0; o < NP; o++) begin : g_o
        // R6: a held-back flit stays presented and unchanged.
        a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] && !out_ready[o] |=> out_valid[o] && $stable(out_flit[o]));
        // R4: ownership persists until the tail leaves.
        a_r4_owner_hold: assert property (@(posedge clk) disable iff (!rst_n)
            out_busy[o] && !(out_valid[o] && out_ready[o] && out_flit[o][TAIL_BIT])
            |=> out_busy[o] && $stable(out_owner[o]));
        // R1: an unowned output never shows a flit.
        a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !out_busy[o] |-> !out_valid[o]);
    end

    for (genvar i = 0; i < NP; i++) begin : g_i
        // R4: one input's worm reserves at most one output.
        a_r4_single_path: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(owned_by[i]) <= 1);
    end
endmodule

bind mesh_router mesh_router_chk #(.FLIT_W(FLIT_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit),
    .out_busy(out_busy), .out_owner(out_owner)
);

// File: tb/tb_mesh_router.sv
module tb_mesh_router;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 5;
    localparam int FW = 10;
    localparam int LOG_MAX = 256;

    logic clk = 0;
    logic rst_n = 0;
    logic [1:0] cur_x = 2'd1, cur_y = 2'd2;
    logic [NP-1:0] in_valid = '0;
    logic [NP-1:0][FW-1:0] in_flit = '0;
    logic [NP-1:0] in_ready;
    logic [NP-1:0] out_valid;
    logic [NP-1:0][FW-1:0] out_flit;
    logic [NP-1:0] out_ready = '1;

    int n_checks = 0, n_fail = 0;
    int log_n = 0;
    int log_port [LOG_MAX];
    logic [FW-1:0] log_flit [LOG_MAX];

    mesh_router dut (
        .clk(clk), .rst_n(rst_n), .cur_x(cur_x), .cur_y(cur_y),
        .in_valid(in_valid), .in_flit(in_flit), .in_ready(in_ready),
        .out_valid(out_valid), .out_flit(out_flit), .out_ready(out_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Record every flit that leaves, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int o = 0; o < NP; o++) begin
                if (out_valid[o] && out_ready[o] && log_n < LOG_MAX) begin
                    log_port[log_n] = o;
                    log_flit[log_n] = out_flit[o];
                    log_n++;
                end
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic int exp_port(int dx, int dy, int cx, int cy);
        if (dx > cx) return 3;
        if (dx < cx) return 4;
        if (dy > cy) return 1;
        if (dy < cy) return 2;
        return 0;
    endfunction

    function automatic logic [FW-1:0] mk_flit(int k, int len, int src, int dx, int dy);
        logic hd, tl;
        logic [7:0] pl;
        hd = (k == 0);
        tl = (k == len - 1);
        if (hd) pl = {1'b0, 3'(src), 2'(dy), 2'(dx)};
        else    pl = {1'b0, 3'(src), 4'(k)};
        return {hd, tl, pl};
    endfunction

    task automatic push(int p, logic [FW-1:0] f);
        @(posedge clk); #1;
        in_valid[p] = 1'b1;
        in_flit[p]  = f;
        forever begin
            @(negedge clk);
            if (in_ready[p]) break;
        end
        @(posedge clk); #1;
        in_valid[p] = 1'b0;
    endtask

    task automatic send_worm(int p, int dx, int dy, int len, int src);
        for (int k = 0; k < len; k++) push(p, mk_flit(k, len, src, dx, dy));
    endtask

    task automatic sweep();
        for (int s = 0; s < NP; s++) begin
            for (int d = 0; d < 16; d++) begin
                int dx, dy;
                dx = d % 4; dy = d / 4;
                log_n = 0;
                send_worm(s, dx, dy, 1, s);
                cycles(6);
                check("R7 single flit delivered once", log_n, 1);
                check("R2 XY output port", log_port[0], exp_port(dx, dy, cur_x, cur_y));
                check("R3 flit bits unchanged", log_flit[0], mk_flit(0, 1, s, dx, dy));
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        cycles(3);
        // R1: reset state
        @(negedge clk);
        check("R1 no valid in reset", out_valid, 0);
        check("R1 inputs ready in reset", in_ready, 5'h1f);
        @(posedge clk); #1;
        rst_n = 1;
        cycles(1);
        @(negedge clk);
        check("R1 no valid after reset", out_valid, 0);
        check("R1 inputs ready after reset", in_ready, 5'h1f);

        // R2/R3/R7: every destination from every input, two positions
        sweep();
        cur_x = 2'd2; cur_y = 2'd1;
        cycles(1);
        sweep();

        // R4: two long worms from east and west inputs to north
        cur_x = 2'd1; cur_y = 2'd1;
        cycles(1);
        log_n = 0;
        fork
            send_worm(3, 1, 3, 5, 3);
            send_worm(4, 1, 3, 5, 4);
        join
        cycles(8);
        check("R4 all flits delivered", log_n, 10);
        begin
            int first;
            first = int'(log_flit[0][6:4]);
            for (int k = 0; k < 10; k++) begin
                int src, idx;
                src = (k < 5) ? first : (first == 3 ? 4 : 3);
                idx = k % 5;
                check("R4 output north", log_port[k], 1);
                check("R4 worm contiguous", log_flit[k], mk_flit(idx, 5, src, 1, 3));
            end
        end

        // R5: continuous contention alternates packet by packet
        log_n = 0;
        fork
            for (int k = 0; k < 3; k++) push(1, mk_flit(0, 1, 1, 1, 1));
            for (int k = 0; k < 3; k++) push(2, mk_flit(0, 1, 2, 1, 1));
        join
        cycles(8);
        check("R5 all single flits delivered", log_n, 6);
        for (int k = 1; k < 6; k++)
            check("R5 winners alternate", (log_flit[k][6:4] != log_flit[k-1][6:4]), 1);

        // R6: backpressure stalls the worm without loss
        log_n = 0;
        out_ready[3] = 1'b0;
        fork
            send_worm(0, 3, 1, 7, 0);
        join_none
        cycles(20);
        check("R6 nothing leaves while not ready", log_n, 0);
        @(negedge clk);
        check("R6 input not ready when FIFO full", in_ready[0], 0);
        check("R6 stalled head presented", out_valid[3], 1);
        check("R6 stalled head value", out_flit[3], mk_flit(0, 7, 0, 3, 1));
        @(posedge clk); #1;
        out_ready[3] = 1'b1;
        wait fork;
        cycles(10);
        check("R6 all flits delivered after stall", log_n, 7);
        for (int k = 0; k < 7; k++) begin
            check("R6 east port", log_port[k], 3);
            check("R3 order kept", log_flit[k], mk_flit(k, 7, 0, 3, 1));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule